// File: doc/BRIEF.md
# PCI MSI capability and message generator

This block holds the Message Signalled Interrupt capability structure of a PCI function and turns the function's interrupt requests into memory-write messages. Software reaches the structure through a dword-addressed configuration port with per-byte enables. The port reads the capability combinationally and writes it on the clock edge. The function raises interrupts through a request port that carries a vector number and a level. Each resulting message leaves as an address/data pair on a valid/ready output port. A separate agent turns that pair into the bus write.

Each vector has a mask bit and a pending bit. A request for a masked vector is remembered in its pending bit. When software later clears that mask bit while MSI is enabled, the message is sent at that point. The low bits of the message data carry the vector number. The enabled-message-count field sets how many low bits are replaced. Messages waiting to leave are kept as one bit per vector and are sent lowest vector first. Parameters select the vector count (1 to 32), the 32-bit or 64-bit address layout, and the next-capability pointer.

Top module: `msi_cap_unit`

## Requirements
- R1: After reset, byte 0 of dword 0 reads 0x05 and byte 1 reads NEXT_PTR. Enable (control bit 0) and the enabled count (control bits 6:4) read 0. The mask and pending registers read 0, and msg_valid is low.
- R2: Writes to byte 0 and byte 1 of dword 0 change nothing that can be read back.
- R3: In the control low byte (byte 2 of dword 0), bits 0 and 6:4 take written values. Bits 3:1 and 7 keep their value. The control high byte (byte 3) always reads 0x01 and ignores writes.
- R4: Control bits 3:1 read the smallest k with 2^k at least NUM_VEC. Control bit 7 reads 1 exactly when the 64-bit layout is built.
- R5: In the 64-bit layout the dwords are: 1 address low, 2 address high, 3 data, 4 mask, 5 pending. In the 32-bit layout they are: 1 address, 2 data, 3 mask, 4 pending. Data is 16 bits in lanes 0 and 1, and bits 31:16 read 0.
- R6: A request is ignored if its level is low, if enable is 0, or if its vector is NUM_VEC or above. Ignored means no message and no pending change, and a low-level request does not clear pending.
- R7: An accepted request for a masked vector sets its pending bit and sends no message.
- R8: An accepted request for an unmasked vector clears its pending bit. Its message is presented on the output two clocks after the request edge when the output is free. The address is {address high, address low}, and the high half is 0 in the 32-bit layout.
- R9: Message data is {16'h0, D} where D is the programmed data with its low N bits replaced by the vector's low N bits. N is the enabled count.
- R10: While enable is 1, a write that takes a mask bit from 1 to 0 while its pending bit is 1 clears the pending bit and queues that vector's message. While enable is 0, such a write leaves pending unchanged and queues nothing.
- R11: Queued vectors leave in ascending order, one per accepted handshake. Address and data are stable while msg_valid is high and msg_ready is low.
- R12: The pending register ignores writes. Mask bits at and above NUM_VEC read 0.
- R13: Once enable reads 0, queued messages that have not yet reached the output are dropped. A message already presented stays until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe for the capability dword |
| cfg_dw | input | 3 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of dword cfg_dw |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | 5 | Requested vector |
| irq_level | input | 1 | Request level, only high can send |
| msg_valid | output | 1 | Message pair is presented |
| msg_ready | input | 1 | Message pair is taken |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The main instance uses eight vectors with the 64-bit layout and a next pointer of 0x40. This exercises address-high and the shifted data, mask and pending dwords, a 3-bit capable field, and enough vectors to replay several pending ones at once in order. A second instance uses five vectors with the 32-bit layout. It brings the other register placement within reach, a capable field rounded up from a count that is not a power of two, and mask bits above the vector count that must read zero. A behavioural model follows the main instance and is compared with its message port on every clock.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] CAP_ID_MSI = 8'h05;

    typedef struct packed {
        logic        valid;
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    // Replace the low cnt_log2 bits of the data word by the vector number.
    function automatic logic [31:0] fold_vector(input logic [15:0] base,
                                                input logic [2:0]  cnt_log2,
                                                input logic [4:0]  vec);
        logic [16:0] span;
        logic [15:0] keep;
        span = (17'd1 << cnt_log2) - 17'd1;
        keep = span[15:0];
        return {16'h0000, (base & ~keep) | ({11'd0, vec} & keep)};
    endfunction

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
    parameter int          NUM_VEC  = 8,
    parameter bit          ADDR64   = 1'b1,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_dw,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               irq_valid,
    input  logic [4:0]         irq_vec,
    input  logic               irq_level,
    output logic               en_o,
    output logic [2:0]         mme_o,
    output logic [63:0]        addr_o,
    output logic [15:0]        data_o,
    output logic [NUM_VEC-1:0] add_o
);
    import msi_cap_pkg::*;

    localparam logic [2:0] DW_CTRL    = 3'd0;
    localparam logic [2:0] DW_ADDR_LO = 3'd1;
    localparam logic [2:0] DW_ADDR_HI = 3'd2;
    localparam logic [2:0] DW_DATA    = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0] DW_MASK    = ADDR64 ? 3'd4 : 3'd3;
    localparam logic [2:0] DW_PEND    = ADDR64 ? 3'd5 : 3'd4;
    localparam logic [2:0] MMC        = 3'($clog2(NUM_VEC));
    localparam logic       IS64       = ADDR64;

    typedef struct packed {
        logic               en;
        logic [2:0]         mme;
        logic [31:0]        alo;
        logic [31:0]        ahi;
        logic [15:0]        data;
        logic [NUM_VEC-1:0] mask;
        logic [NUM_VEC-1:0] pend;
    } st_t;

    st_t                st_d, st_q;
    logic [NUM_VEC-1:0] add_d;
    logic               irq_hit;

    assign irq_hit = irq_valid && irq_level && st_q.en;

    always_comb begin
        st_d  = st_q;
        add_d = '0;
        if (cfg_wr) begin
            if (cfg_dw == DW_CTRL && cfg_be[2]) begin
                st_d.en  = cfg_wdata[16];
                st_d.mme = cfg_wdata[22:20];
            end
            if (cfg_dw == DW_ADDR_LO) begin
                for (int b = 0; b < 4; b++)
                    if (cfg_be[b]) st_d.alo[8*b +: 8] = cfg_wdata[8*b +: 8];
            end
            if (IS64 && cfg_dw == DW_ADDR_HI) begin
                for (int b = 0; b < 4; b++)
                    if (cfg_be[b]) st_d.ahi[8*b +: 8] = cfg_wdata[8*b +: 8];
            end
            if (cfg_dw == DW_DATA) begin
                for (int b = 0; b < 2; b++)
                    if (cfg_be[b]) st_d.data[8*b +: 8] = cfg_wdata[8*b +: 8];
            end
            if (cfg_dw == DW_MASK) begin
                for (int i = 0; i < NUM_VEC; i++) begin
                    if (cfg_be[i/8]) begin
                        st_d.mask[i] = cfg_wdata[i];
                        if (st_q.en && st_q.mask[i] && !cfg_wdata[i] && st_q.pend[i]) begin
                            add_d[i]     = 1'b1;
                            st_d.pend[i] = 1'b0;
                        end
                    end
                end
            end
        end
        if (irq_hit) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (irq_vec == 5'(i)) begin
                    if (st_q.mask[i]) begin
                        st_d.pend[i] = 1'b1;
                    end else begin
                        st_d.pend[i] = 1'b0;
                        add_d[i]     = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_dw == DW_CTRL)
            cfg_rdata = {8'h01, IS64, st_q.mme, MMC, st_q.en, NEXT_PTR, CAP_ID_MSI};
        else if (cfg_dw == DW_ADDR_LO)
            cfg_rdata = st_q.alo;
        else if (IS64 && cfg_dw == DW_ADDR_HI)
            cfg_rdata = st_q.ahi;
        else if (cfg_dw == DW_DATA)
            cfg_rdata = {16'h0000, st_q.data};
        else if (cfg_dw == DW_MASK)
            cfg_rdata = 32'(st_q.mask);
        else if (cfg_dw == DW_PEND)
            cfg_rdata = 32'(st_q.pend);
    end

    assign en_o   = st_q.en;
    assign mme_o  = st_q.mme;
    assign addr_o = IS64 ? {st_q.ahi, st_q.alo} : {32'h0, st_q.alo};
    assign data_o = st_q.data;
    assign add_o  = add_d;

    AST_PEND_SET_BY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_valid && irq_level) |=> ((st_q.pend & ~$past(st_q.pend)) == '0)); // R7
    AST_PEND_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && !cfg_wr) |=> ((~st_q.pend & $past(st_q.pend)) == '0)); // R10

endmodule

// File: rtl/msi_vec_queue.sv
module msi_vec_queue #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [NUM_VEC-1:0] add_i,
    input  logic               take_i,
    output logic               head_valid_o,
    output logic [4:0]         head_idx_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] bits;
    } st_t;

    st_t                st_d, st_q;
    logic [NUM_VEC:0]   seen;
    logic [NUM_VEC-1:0] first;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_pick
        assign first[g]  = st_q.bits[g] & ~seen[g];
        assign seen[g+1] = seen[g] | st_q.bits[g];
    end

    always_comb begin
        head_idx_o = '0;
        for (int i = 0; i < NUM_VEC; i++)
            if (first[i]) head_idx_o = head_idx_o | 5'(i);
    end
    assign head_valid_o = seen[NUM_VEC];

    always_comb begin
        st_d = st_q;
        if (!en_i) st_d.bits = '0;
        else       st_d.bits = (st_q.bits & ~(take_i ? first : '0)) | add_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TAKE_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> head_valid_o); // R11

endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        head_valid_i,
    input  logic [4:0]  head_idx_i,
    input  logic [63:0] addr_i,
    input  logic [15:0] data_i,
    input  logic [2:0]  mme_i,
    output logic        take_o,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data
);
    import msi_cap_pkg::*;

    msg_t st_d, st_q;
    logic free;

    assign free   = !st_q.valid || msg_ready;
    assign take_o = free && en_i && head_valid_i;

    always_comb begin
        st_d = st_q;
        if (free) begin
            st_d.valid = take_o;
            if (take_o) begin
                st_d.addr = addr_i;
                st_d.data = fold_vector(data_i, mme_i, head_idx_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msg_valid = st_q.valid;
    assign msg_addr  = st_q.addr;
    assign msg_data  = st_q.data;

    AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R11
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !msg_valid) |=> !msg_valid); // R13

endmodule

// File: rtl/msi_cap_unit.sv
module msi_cap_unit #(
    parameter int         NUM_VEC  = 8,
    parameter bit         ADDR64   = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        irq_valid,
    input  logic [4:0]  irq_vec,
    input  logic        irq_level,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data
);
    logic               en;
    logic [2:0]         mme;
    logic [63:0]        addr;
    logic [15:0]        data;
    logic [NUM_VEC-1:0] add;
    logic               take;
    logic               head_valid;
    logic [4:0]         head_idx;

    msi_cap_regs #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_level(irq_level),
        .en_o(en), .mme_o(mme), .addr_o(addr), .data_o(data), .add_o(add)
    );

    msi_vec_queue #(.NUM_VEC(NUM_VEC)) u_queue (
        .clk(clk), .rst_n(rst_n), .en_i(en), .add_i(add), .take_i(take),
        .head_valid_o(head_valid), .head_idx_o(head_idx)
    );

    msi_msg_out u_out (
        .clk(clk), .rst_n(rst_n), .en_i(en),
        .head_valid_i(head_valid), .head_idx_i(head_idx),
        .addr_i(addr), .data_i(data), .mme_i(mme),
        .take_o(take), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

endmodule

// File: tb/msi_cap_unit_tb.sv
module msi_cap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, b_wr = 0;
    logic [2:0]  a_dw = 0, b_dw = 0;
    logic [3:0]  a_be = 0, b_be = 0;
    logic [31:0] a_wd = 0, b_wd = 0;
    logic [31:0] a_rd, b_rd;
    logic        irq_valid = 0, irq_level = 0;
    logic [4:0]  irq_vec = 0;
    logic        msg_ready = 1;
    logic        msg_valid, b_valid;
    logic [63:0] msg_addr, b_addr;
    logic [31:0] msg_data, b_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    msi_cap_unit #(.NUM_VEC(8), .ADDR64(1'b1), .NEXT_PTR(8'h40)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(a_wr), .cfg_dw(a_dw), .cfg_be(a_be),
        .cfg_wdata(a_wd), .cfg_rdata(a_rd), .irq_valid(irq_valid), .irq_vec(irq_vec),
        .irq_level(irq_level), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    msi_cap_unit #(.NUM_VEC(5), .ADDR64(1'b0), .NEXT_PTR(8'h00)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_wr(b_wr), .cfg_dw(b_dw), .cfg_be(b_be),
        .cfg_wdata(b_wd), .cfg_rdata(b_rd), .irq_valid(1'b0), .irq_vec(5'd0),
        .irq_level(1'b0), .msg_valid(b_valid), .msg_ready(1'b1),
        .msg_addr(b_addr), .msg_data(b_data)
    );

    // ---------------- behavioural reference of the 64-bit, 8-vector instance
    bit          m_en;
    bit [2:0]    m_mme;
    bit [31:0]   m_alo, m_ahi;
    bit [15:0]   m_data;
    bit [7:0]    m_mask, m_pend;
    int          mq[$];
    bit          m_ov;
    bit [63:0]   m_oaddr;
    bit [31:0]   m_odata;

    function automatic bit [31:0] ref_data(bit [15:0] d, bit [2:0] n, int v);
        int k;
        k = (1 << n) - 1;
        return {16'h0, (d & ~16'(k)) | (16'(v) & 16'(k))};
    endfunction

    function automatic void push_vec(int v);
        int pos;
        foreach (mq[j]) if (mq[j] == v) return;
        pos = 0;
        while (pos < mq.size() && mq[pos] < v) pos++;
        mq.insert(pos, v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_data = 0;
            m_mask = 0; m_pend = 0; mq.delete(); m_ov = 0;
        end else begin
            bit       en_pre;
            bit [7:0] mask_pre;
            en_pre   = m_en;
            mask_pre = m_mask;
            if (!m_ov || msg_ready) begin
                if (en_pre && mq.size() > 0) begin
                    int v;
                    v = mq.pop_front();
                    m_ov = 1;
                    m_oaddr = {m_ahi, m_alo};
                    m_odata = ref_data(m_data, m_mme, v);
                end else m_ov = 0;
            end
            if (!en_pre) mq.delete();
            if (a_wr) begin
                if (a_dw == 0 && a_be[2]) begin m_en = a_wd[16]; m_mme = a_wd[22:20]; end
                for (int b = 0; b < 4; b++) begin
                    if (a_be[b] && a_dw == 1) m_alo[8*b +: 8] = a_wd[8*b +: 8];
                    if (a_be[b] && a_dw == 2) m_ahi[8*b +: 8] = a_wd[8*b +: 8];
                    if (a_be[b] && a_dw == 3 && b < 2) m_data[8*b +: 8] = a_wd[8*b +: 8];
                end
                if (a_dw == 4 && a_be[0]) begin
                    for (int i = 0; i < 8; i++) begin
                        if (mask_pre[i] && !a_wd[i] && m_pend[i] && en_pre) begin
                            push_vec(i);
                            m_pend[i] = 0;
                        end
                        m_mask[i] = a_wd[i];
                    end
                end
            end
            if (irq_valid && irq_level && en_pre && irq_vec < 8) begin
                if (mask_pre[irq_vec[2:0]]) m_pend[irq_vec[2:0]] = 1;
                else begin
                    m_pend[irq_vec[2:0]] = 0;
                    push_vec(int'(irq_vec));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (msg_valid !== m_ov) begin
                errors++;
                $display("FAIL R8 R11 R13 msg_valid actual %0b expected %0b at cycle %0d", msg_valid, m_ov, cyc);
            end else if (m_ov && (msg_addr !== m_oaddr || msg_data !== m_odata)) begin
                errors++;
                $display("FAIL R8 R9 R11 payload actual %h/%h expected %h/%h", msg_addr, msg_data, m_oaddr, m_odata);
            end
        end
    end

    // ---------------- helpers
    task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_a(logic [2:0] dw, logic [3:0] be, logic [31:0] wd);
        @(negedge clk); a_wr = 1; a_dw = dw; a_be = be; a_wd = wd;
        @(negedge clk); a_wr = 0;
    endtask

    task automatic wr_b(logic [2:0] dw, logic [3:0] be, logic [31:0] wd);
        @(negedge clk); b_wr = 1; b_dw = dw; b_be = be; b_wd = wd;
        @(negedge clk); b_wr = 0;
    endtask

    task automatic rd_a(logic [2:0] dw, output logic [31:0] v);
        @(negedge clk); a_dw = dw; #1; v = a_rd;
    endtask

    task automatic rd_b(logic [2:0] dw, output logic [31:0] v);
        @(negedge clk); b_dw = dw; #1; v = b_rd;
    endtask

    task automatic irq(logic [4:0] v, logic lvl);
        @(negedge clk); irq_valid = 1; irq_vec = v; irq_level = lvl;
        @(negedge clk); irq_valid = 0; irq_level = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual %0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        idle(3);
        rst_n = 1;
        check_eq("R1 msg_valid after reset", {63'd0, msg_valid}, 64'd0);
        rd_a(3'd0, r); check_eq("R1 R4 dword0 reset", {32'd0, r}, 64'h01864005);
        rd_a(3'd4, r); check_eq("R1 mask reset", {32'd0, r}, 64'h0);
        rd_a(3'd5, r); check_eq("R1 pending reset", {32'd0, r}, 64'h0);

        wr_a(3'd0, 4'hF, 32'hFFFF_FFFF);
        rd_a(3'd0, r); check_eq("R2 R3 dword0 after full write", {32'd0, r}, 64'h01F74005);
        wr_a(3'd0, 4'h4, 32'h0021_0000);
        rd_a(3'd0, r); check_eq("R3 enable and count", {32'd0, r}, 64'h01A74005);

        wr_a(3'd1, 4'hF, 32'hFEE0_1000);
        wr_a(3'd2, 4'hF, 32'h0000_0001);
        wr_a(3'd3, 4'hF, 32'hFFFF_ABC8);
        rd_a(3'd1, r); check_eq("R5 address low", {32'd0, r}, 64'hFEE01000);
        rd_a(3'd2, r); check_eq("R5 address high", {32'd0, r}, 64'h1);
        rd_a(3'd3, r); check_eq("R5 data upper zero", {32'd0, r}, 64'h0000ABC8);

        irq(5'd3, 1'b0);
        irq(5'd9, 1'b1);
        rd_a(3'd5, r); check_eq("R6 no pending from ignored requests", {32'd0, r}, 64'h0);
        check_eq("R6 no message from ignored requests", {63'd0, msg_valid}, 64'd0);

        irq(5'd5, 1'b1);
        @(negedge clk);
        check_eq("R8 message presented", {63'd0, msg_valid}, 64'd1);
        check_eq("R8 message address", msg_addr, 64'h00000001_FEE01000);
        check_eq("R9 message data folded", {32'd0, msg_data}, 64'h0000ABC9);
        idle(2);

        wr_a(3'd4, 4'hF, 32'h0000_00FF);
        irq(5'd2, 1'b1); irq(5'd6, 1'b1); irq(5'd1, 1'b1);
        idle(2);
        rd_a(3'd5, r); check_eq("R7 pending latched", {32'd0, r}, 64'h46);
        check_eq("R7 no message while masked", {63'd0, msg_valid}, 64'd0);

        wr_a(3'd5, 4'hF, 32'hFFFF_FFFF);
        rd_a(3'd5, r); check_eq("R12 pending ignores writes", {32'd0, r}, 64'h46);
        wr_a(3'd4, 4'hF, 32'hFFFF_FFFF);
        rd_a(3'd4, r); check_eq("R12 mask bits above count", {32'd0, r}, 64'hFF);

        msg_ready = 0;
        wr_a(3'd4, 4'hF, 32'h0);
        rd_a(3'd5, r); check_eq("R10 pending cleared on replay", {32'd0, r}, 64'h0);
        check_eq("R11 first replay is lowest vector", {32'd0, msg_data}, 64'h0000ABC9);
        idle(4);
        msg_ready = 1;
        idle(6);

        wr_a(3'd4, 4'h1, 32'h0000_00FF);
        irq(5'd4, 1'b1);
        irq(5'd4, 1'b0);
        rd_a(3'd5, r); check_eq("R6 low level keeps pending", {32'd0, r}, 64'h10);
        wr_a(3'd0, 4'h4, 32'h0020_0000);
        wr_a(3'd4, 4'h1, 32'h0);
        irq(5'd0, 1'b1);
        idle(3);
        rd_a(3'd5, r); check_eq("R10 no replay while disabled", {32'd0, r}, 64'h10);
        check_eq("R6 R10 no message while disabled", {63'd0, msg_valid}, 64'd0);
        wr_a(3'd0, 4'h4, 32'h0021_0000);
        wr_a(3'd4, 4'h1, 32'h10);
        wr_a(3'd4, 4'h1, 32'h0);
        @(negedge clk);
        check_eq("R10 replay after re-enable", {32'd0, msg_data}, 64'h0000ABC8);
        idle(3);

        msg_ready = 0;
        irq(5'd0, 1'b1); irq(5'd1, 1'b1); irq(5'd2, 1'b1);
        wr_a(3'd0, 4'h4, 32'h0020_0000);
        idle(2);
        msg_ready = 1;
        idle(4);
        check_eq("R13 queued messages dropped", {63'd0, msg_valid}, 64'd0);

        rd_b(3'd0, r); check_eq("R4 32-bit dword0", {32'd0, r}, 64'h01060005);
        wr_b(3'd0, 4'hF, 32'hFFFF_FFFF);
        rd_b(3'd0, r); check_eq("R3 32-bit control", {32'd0, r}, 64'h01770005);
        wr_b(3'd2, 4'hF, 32'hFFFF_1234);
        rd_b(3'd2, r); check_eq("R5 32-bit data", {32'd0, r}, 64'h00001234);
        wr_b(3'd3, 4'hF, 32'hFFFF_FFFF);
        rd_b(3'd3, r); check_eq("R12 32-bit mask width", {32'd0, r}, 64'h1F);
        rd_b(3'd4, r); check_eq("R5 32-bit pending", {32'd0, r}, 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule